// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block collects interrupt requests from sixteen external pins and from a set of on-chip peripheral sources. It presents a single winning vector number, with that source's priority level, to the processor. Each external pin goes through a synchronizer and a selectable level or edge detector. The detector sets a sticky request flag, which a per-pin enable bit gates. An internal source arrives as a status flag and is gated by its own enable bit.

Two ordering modes are available. In the fixed mode, the lowest source index wins, and one mask bit from the processor blocks every source. In the leveled mode, every pair of neighbouring sources forms a module with a programmable 3-bit level. The highest eligible level wins, and the lower vector number settles ties and the order inside a module. A source is eligible only when its level is above the processor's mask level, or when its level is 7. Internal sources can be steered to a DMA trigger output that ignores the mode and every mask. A steered source no longer competes for the processor. The configuration sits in a small register file behind an address, data and write-strobe port.

Top module: `ipc_top`

## Requirements
- R1: After reset, irq_req, irq_vec, irq_lvl and dma_trig are 0 and every register reads 0.
- R2: Pin p uses sense field bits [2p+1:2p] at address 2: 00 = low level, 01 = falling edge, 10 = rising edge, 11 = either edge. A detected event sets flag p. Flag p becomes visible on the outputs four clock edges after the pin changes, because the path runs through two synchronizer stages, the flag and the output register.
- R3: An external flag stays set after its pin returns to idle. Writing 1 to bit p at address 7 clears flag p, and address 7 also reads the flags back. A detection in the same cycle as the clear wins over the clear.
- R4: A source is requested only when its enable bit is 1: bit p at address 0 for pin p, and bit k at address 1 for internal source k. A flag still sets while its enable bit is 0.
- R5: Source index i is pin i for i < 16 and internal source i-16 otherwise, and its vector is 16+i. In fixed mode (address 3 bit 0 = 0), the lowest requesting index wins and irq_lvl is 0.
- R6: In fixed mode, cpu_mask_bit = 1 blocks every source from irq_req.
- R7: In leveled mode (address 3 bit 0 = 1), source i belongs to module i/2. Module m has its level in bits [4(m%8)+2 : 4(m%8)] of address 5+m/8. The highest level wins, equal levels fall back to the lower vector, and irq_lvl reports the winner's level.
- R8: In leveled mode, a source is eligible only if its level is strictly greater than cpu_mask_lvl, or if its level is 7.
- R9: The outputs are registered. At a clock edge where irq_ack is 1, they keep their values.
- R10: At an edge where irq_ack is 1 and irq_req presents pin p, flag p is cleared if pin p is in an edge mode. A flag in level mode is not cleared.
- R11: dma_trig[k] is 1 exactly when internal flag k, enable bit k and steering bit k (address 4) are all 1, whatever the mode and masks. A steered source takes no part in processor arbitration.
- R12: Each writable field reads back at its own address, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | N_EXT | External request pins, idle high |
| int_flag | input | N_INT | Status flags from internal peripherals |
| reg_addr | input | AW | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| cpu_mask_lvl | input | 3 | Processor mask level (leveled mode) |
| cpu_mask_bit | input | 1 | Processor mask bit (fixed mode) |
| irq_ack | input | 1 | Processor acknowledge |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Winning vector number |
| irq_lvl | output | 3 | Winning level |
| dma_trig | output | N_INT | DMA trigger lines |

## Verification
Each pin is driven with falls, rises and held-low levels under all four sense codes. This shows whether a pin sets its flag only on the events its code names, and whether a level-mode flag survives an acknowledge that clears an edge-mode flag. Several winners are built across two modules with equal, unequal and saturated levels, and the mask level is swept around them. This separates a programmed-level choice from a vector-order choice, and a strict comparison from a non-strict one. A long random mix of pins, peripheral flags, acknowledges, mask changes and register writes is then checked each cycle against a behavioural model. That mix catches set-versus-clear collisions and hold-on-acknowledge slips.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
   localparam int LVL_W = 3;
   localparam int MODS_PER_WORD = 8;

   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_FALL = 2'b01,
      SNS_RISE = 2'b10,
      SNS_BOTH = 2'b11
   } sense_e;

   localparam int ADDR_EXT_EN = 0;
   localparam int ADDR_INT_EN = 1;
   localparam int ADDR_SENSE  = 2;
   localparam int ADDR_CTRL   = 3;
   localparam int ADDR_DMA    = 4;
   localparam int ADDR_LVL0   = 5;
   localparam int ADDR_FLAGS  = 7;
endpackage

// File: rtl/ipc_pin_detect.sv
module ipc_pin_detect
   import ipc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] sense,
   input  logic       clr,
   output logic       flag
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   det;

   assign cur = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= cur;
      end
   end

   always_comb begin
      case (sense_e'(sense))
         SNS_LOW:  det = ~cur;
         SNS_FALL: det = prev_q & ~cur;
         SNS_RISE: det = ~prev_q & cur;
         default:  det = prev_q ^ cur;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~clr) | det;
   end
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
   import ipc_pkg::*;
#(
   parameter int N_EXT = 16,
   parameter int N_INT = 8,
   parameter int N_MOD = 12,
   parameter int AW    = 4,
   parameter int DW    = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          addr,
   input  logic                   we,
   input  logic [DW-1:0]          wdata,
   output logic [DW-1:0]          rdata,
   input  logic [N_EXT-1:0]       ext_flags,
   output logic [N_EXT-1:0]       ext_en,
   output logic [N_INT-1:0]       int_en,
   output logic [2*N_EXT-1:0]     sense,
   output logic                   mode2,
   output logic [N_INT-1:0]       dma_sel,
   output logic [N_MOD*LVL_W-1:0] lvl_flat,
   output logic [N_EXT-1:0]       flag_w1c
);
   logic [LVL_W-1:0] lvl_q [N_MOD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_en  <= '0;
         int_en  <= '0;
         sense   <= '0;
         mode2   <= 1'b0;
         dma_sel <= '0;
      end else if (we) begin
         if (addr == AW'(ADDR_EXT_EN)) ext_en  <= wdata[N_EXT-1:0];
         if (addr == AW'(ADDR_INT_EN)) int_en  <= wdata[N_INT-1:0];
         if (addr == AW'(ADDR_SENSE))  sense   <= wdata[2*N_EXT-1:0];
         if (addr == AW'(ADDR_CTRL))   mode2   <= wdata[0];
         if (addr == AW'(ADDR_DMA))    dma_sel <= wdata[N_INT-1:0];
      end
   end

   for (genvar m = 0; m < N_MOD; m++) begin : g_lvl
      localparam int WORD = ADDR_LVL0 + m / MODS_PER_WORD;
      localparam int LSB  = 4 * (m % MODS_PER_WORD);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q[m] <= '0;
         else if (we && addr == AW'(WORD)) lvl_q[m] <= wdata[LSB +: LVL_W];
      end
      assign lvl_flat[m*LVL_W +: LVL_W] = lvl_q[m];
   end

   assign flag_w1c = (we && addr == AW'(ADDR_FLAGS)) ? wdata[N_EXT-1:0] : '0;

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(ADDR_EXT_EN): rdata[N_EXT-1:0]   = ext_en;
         AW'(ADDR_INT_EN): rdata[N_INT-1:0]   = int_en;
         AW'(ADDR_SENSE):  rdata[2*N_EXT-1:0] = sense;
         AW'(ADDR_CTRL):   rdata[0]           = mode2;
         AW'(ADDR_DMA):    rdata[N_INT-1:0]   = dma_sel;
         AW'(ADDR_FLAGS):  rdata[N_EXT-1:0]   = ext_flags;
         default:          rdata              = '0;
      endcase
      for (int m = 0; m < N_MOD; m++) begin
         if (addr == AW'(ADDR_LVL0 + m / MODS_PER_WORD))
            rdata[4*(m % MODS_PER_WORD) +: LVL_W] = lvl_q[m];
      end
   end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
   import ipc_pkg::*;
#(
   parameter int NSRC        = 24,
   parameter int SRC_PER_MOD = 2,
   parameter int N_MOD       = 12,
   parameter int IDX_W       = 5
) (
   input  logic [NSRC-1:0]        req,
   input  logic [N_MOD*LVL_W-1:0] lvl_flat,
   input  logic                   mode2,
   input  logic [LVL_W-1:0]       mask_lvl,
   input  logic                   mask_bit,
   output logic                   found,
   output logic [IDX_W-1:0]       win_idx,
   output logic [LVL_W-1:0]       win_lvl
);
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         logic [LVL_W-1:0] lv;
         logic             ok;
         lv = lvl_flat[(i / SRC_PER_MOD) * LVL_W +: LVL_W];
         ok = mode2 ? ((lv > mask_lvl) || (lv == {LVL_W{1'b1}})) : ~mask_bit;
         if (req[i] && ok && (!found || !mode2 || lv >= win_lvl)) begin
            found   = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lv;
         end
      end
   end
endmodule

// File: rtl/ipc_top.sv
module ipc_top
   import ipc_pkg::*;
#(
   parameter int N_EXT       = 16,
   parameter int N_INT       = 8,
   parameter int SRC_PER_MOD = 2,
   parameter int VEC_BASE    = 16,
   parameter int VEC_W       = 8,
   parameter int AW          = 4,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] ext_pin,
   input  logic [N_INT-1:0] int_flag,
   input  logic [AW-1:0]    reg_addr,
   input  logic             reg_we,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic [2:0]       cpu_mask_lvl,
   input  logic             cpu_mask_bit,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic [2:0]       irq_lvl,
   output logic [N_INT-1:0] dma_trig
);
   localparam int NSRC  = N_EXT + N_INT;
   localparam int N_MOD = NSRC / SRC_PER_MOD;
   localparam int IDX_W = $clog2(NSRC);

   if (N_EXT < 1 || N_EXT > 16) begin : g_chk_ext
      $error("N_EXT must be 1..16");
   end
   if (N_INT < 1 || N_INT > DW) begin : g_chk_int
      $error("N_INT must be 1..DW");
   end
   if (NSRC % SRC_PER_MOD != 0) begin : g_chk_mod
      $error("source count must divide into whole modules");
   end
   if (N_MOD > 2 * MODS_PER_WORD) begin : g_chk_nmod
      $error("at most two level words");
   end
   if (VEC_BASE + NSRC > (1 << VEC_W)) begin : g_chk_vec
      $error("vector range exceeds VEC_W");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DW != 32 || AW < 3) begin : g_chk_bus
      $error("register port must be 32 bits wide with at least 3 address bits");
   end

   logic [N_EXT-1:0]       ext_flag;
   logic [N_EXT-1:0]       ext_en;
   logic [N_INT-1:0]       int_en;
   logic [2*N_EXT-1:0]     sense;
   logic                   mode2;
   logic [N_INT-1:0]       dma_sel;
   logic [N_MOD*LVL_W-1:0] lvl_flat;
   logic [N_EXT-1:0]       flag_w1c;
   logic [N_EXT-1:0]       ack_clr;
   logic [NSRC-1:0]        src_req;
   logic                   found;
   logic [IDX_W-1:0]       win_idx;
   logic [LVL_W-1:0]       win_lvl;

   ipc_regs #(
      .N_EXT(N_EXT), .N_INT(N_INT), .N_MOD(N_MOD), .AW(AW), .DW(DW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
      .wdata(reg_wdata), .rdata(reg_rdata), .ext_flags(ext_flag),
      .ext_en(ext_en), .int_en(int_en), .sense(sense), .mode2(mode2),
      .dma_sel(dma_sel), .lvl_flat(lvl_flat), .flag_w1c(flag_w1c)
   );

   for (genvar p = 0; p < N_EXT; p++) begin : g_pin
      localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(VEC_BASE + p);
      assign ack_clr[p] = irq_ack && irq_req && (irq_vec == MY_VEC) &&
                          (sense[2*p +: 2] != SNS_LOW);
      ipc_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
         .clk(clk), .rst_n(rst_n), .pin(ext_pin[p]),
         .sense(sense[2*p +: 2]), .clr(flag_w1c[p] | ack_clr[p]),
         .flag(ext_flag[p])
      );
   end

   assign src_req  = {int_flag & int_en & ~dma_sel, ext_flag & ext_en};
   assign dma_trig = int_flag & int_en & dma_sel;

   ipc_arbiter #(
      .NSRC(NSRC), .SRC_PER_MOD(SRC_PER_MOD), .N_MOD(N_MOD), .IDX_W(IDX_W)
   ) u_arb (
      .req(src_req), .lvl_flat(lvl_flat), .mode2(mode2),
      .mask_lvl(cpu_mask_lvl), .mask_bit(cpu_mask_bit),
      .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_vec <= '0;
         irq_lvl <= '0;
      end else if (!irq_ack) begin
         irq_req <= found;
         irq_vec <= found ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : '0;
         irq_lvl <= (found && mode2) ? win_lvl : '0;
      end
   end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
   parameter int N_INT    = 8,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 16,
   parameter int NSRC     = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_ack,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic [2:0]       irq_lvl,
   input logic             mode2,
   input logic [2:0]       cpu_mask_lvl,
   input logic             cpu_mask_bit,
   input logic [N_INT-1:0] int_flag,
   input logic [N_INT-1:0] dma_trig
);
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == '0 && irq_lvl == '0));

   a_r5_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec < VEC_W'(VEC_BASE + NSRC)));

   a_r6_mask_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode2 && cpu_mask_bit && !irq_ack) |=> !irq_req);

   a_r8_mask_lvl: assert property (@(posedge clk) disable iff (!rst_n)
      (mode2 && !irq_ack) |=> (!irq_req || irq_lvl == 3'd7 || irq_lvl > $past(cpu_mask_lvl)));

   a_r9_hold_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> ($stable(irq_req) && $stable(irq_vec) && $stable(irq_lvl)));

   a_r11_dma_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_trig & ~int_flag) == '0);
endmodule

bind ipc_top ipc_checker #(
   .N_INT(N_INT), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .NSRC(N_EXT + N_INT)
) u_ipc_checker (
   .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_req(irq_req),
   .irq_vec(irq_vec), .irq_lvl(irq_lvl), .mode2(mode2),
   .cpu_mask_lvl(cpu_mask_lvl), .cpu_mask_bit(cpu_mask_bit),
   .int_flag(int_flag), .dma_trig(dma_trig)
);

// File: tb/tb_ipc_top.sv
`timescale 1ns/1ps
module tb_ipc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ext_pin = 16'hFFFF;
   logic [7:0]  int_flag = '0;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  cpu_mask_lvl = '0;
   logic        cpu_mask_bit = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [7:0]  irq_vec;
   logic [2:0]  irq_lvl;
   logic [7:0]  dma_trig;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   string cur_req = "R1";

   ipc_top dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_flag(int_flag),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cpu_mask_lvl(cpu_mask_lvl),
      .cpu_mask_bit(cpu_mask_bit), .irq_ack(irq_ack), .irq_req(irq_req),
      .irq_vec(irq_vec), .irq_lvl(irq_lvl), .dma_trig(dma_trig)
   );

   always #5 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_ext_en, m_int_en, m_sense, m_dma;
   bit        m_mode;
   int        m_lvl [16];
   bit [15:0] m_flag;
   bit        m_req;
   int        m_vec, m_lvo;
   logic [15:0] pin_q [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ext_en = 0; m_int_en = 0; m_sense = 0; m_dma = 0; m_mode = 0;
         foreach (m_lvl[j]) m_lvl[j] = 0;
         m_flag = 0; m_req = 0; m_vec = 0; m_lvo = 0;
         pin_q = {16'hFFFF, 16'hFFFF, 16'hFFFF};
      end else begin
         bit [15:0] nflag;
         int best, bestl;
         logic [15:0] now_v, old_v;
         now_v = pin_q[1];
         old_v = pin_q[0];
         for (int p = 0; p < 16; p++) begin
            bit ev, cl;
            case ({m_sense[2*p+1], m_sense[2*p]})
               2'b00: ev = !now_v[p];
               2'b01: ev = old_v[p] && !now_v[p];
               2'b10: ev = !old_v[p] && now_v[p];
               default: ev = old_v[p] != now_v[p];
            endcase
            cl = (reg_we && reg_addr == 7 && reg_wdata[p]) ||
                 (irq_ack && m_req && m_vec == 16 + p &&
                  {m_sense[2*p+1], m_sense[2*p]} != 2'b00);
            nflag[p] = ev ? 1'b1 : (cl ? 1'b0 : m_flag[p]);
         end
         best = -1; bestl = -1;
         for (int s = 0; s < 24; s++) begin
            bit r, ok;
            int lv, eff;
            if (s < 16) r = m_flag[s] && m_ext_en[s];
            else        r = int_flag[s-16] && m_int_en[s-16] && !m_dma[s-16];
            lv  = m_lvl[s/2];
            ok  = m_mode ? (lv > int'(cpu_mask_lvl) || lv == 7) : !cpu_mask_bit;
            eff = m_mode ? lv : 0;
            if (r && ok && eff > bestl) begin best = s; bestl = eff; end
         end
         if (!irq_ack) begin
            m_req = (best >= 0);
            m_vec = m_req ? 16 + best : 0;
            m_lvo = (m_req && m_mode) ? bestl : 0;
         end
         pin_q.push_back(ext_pin);
         void'(pin_q.pop_front());
         m_flag = nflag;
         if (reg_we) begin
            case (reg_addr)
               0: m_ext_en = reg_wdata & 32'hFFFF;
               1: m_int_en = reg_wdata & 32'hFF;
               2: m_sense  = reg_wdata;
               3: m_mode   = reg_wdata[0];
               4: m_dma    = reg_wdata & 32'hFF;
               5: for (int k = 0; k < 8; k++) m_lvl[k]   = (reg_wdata >> (4*k)) & 7;
               6: for (int k = 0; k < 4; k++) m_lvl[8+k] = (reg_wdata >> (4*k)) & 7;
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         check({cur_req, " model compare"},
               {int'(dma_trig), 4'(irq_lvl), 8'(irq_vec), 4'(irq_req)},
               {8'(int_flag & m_int_en[7:0] & m_dma[7:0]), 4'(m_lvo), 8'(m_vec), 4'(m_req)});
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = 4'(a);
      #2;
      check(tag, reg_rdata, exp);
   endtask

   task automatic out_chk(input bit r, input int v, input int l, input string tag);
      #2;
      check(tag, {int'(irq_lvl), 8'(irq_vec), 4'(irq_req)}, {l, 8'(v), 4'(r)});
   endtask

   task automatic pin_set(input int p, input bit v);
      @(negedge clk);
      ext_pin[p] = v;
   endtask

   task automatic ack_pulse(input string tag, input bit r, input int v, input int l);
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      out_chk(r, v, l, tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R1 reset state
      out_chk(0, 0, 0, "R1 outputs after reset");
      check("R1 dma_trig after reset", 32'(dma_trig), 0);
      for (int a = 0; a < 8; a++) rd_chk(a, 0, "R1 register reset value");

      // R12 read-back with unused bits
      cur_req = "R12";
      wr(0, 32'hFFFFFFFF); rd_chk(0, 32'h0000FFFF, "R12 ext enable readback");
      wr(1, 32'hFFFFFFFF); rd_chk(1, 32'h000000FF, "R12 int enable readback");
      wr(2, 32'hA5C3_0F1E); rd_chk(2, 32'hA5C3_0F1E, "R12 sense readback");
      wr(3, 32'hFFFFFFFF); rd_chk(3, 32'h1, "R12 mode readback");
      wr(4, 32'h0000_1234); rd_chk(4, 32'h34, "R12 steering readback");
      wr(5, 32'hFFFFFFFF); rd_chk(5, 32'h77777777, "R12 level word 0 readback");
      wr(6, 32'hFFFFFFFF); rd_chk(6, 32'h00007777, "R12 level word 1 readback");
      for (int a = 0; a < 7; a++) wr(a, 0);
      wr(7, 32'hFFFF);
      wait_cyc(2);

      // R2 / R5 edge and level detection, fixed mode
      cur_req = "R2";
      wr(2, 32'h0000_0139);   // pin0 fall, pin1 rise, pin2 both, pin3 level, pin4 fall
      wr(0, 32'h0000_000F);
      pin_set(0, 0); wait_cyc(6);
      out_chk(1, 16, 0, "R2 falling edge on pin0 gives vector 16 (R5)");
      cur_req = "R3";
      pin_set(0, 1); wait_cyc(6);
      out_chk(1, 16, 0, "R3 flag sticky after pin returns");
      rd_chk(7, 32'h1, "R3 flag readback");
      cur_req = "R9";
      ack_pulse("R9 outputs held across acknowledge edge", 1, 16, 0);
      cur_req = "R10";
      wait_cyc(3);
      out_chk(0, 0, 0, "R10 acknowledge clears edge flag");
      cur_req = "R2";
      pin_set(1, 0); wait_cyc(6);
      out_chk(0, 0, 0, "R2 falling edge ignored in rising mode");
      pin_set(1, 1); wait_cyc(6);
      out_chk(1, 17, 0, "R2 rising edge on pin1");
      pin_set(3, 0); wait_cyc(6);
      out_chk(1, 17, 0, "R5 lower index wins over pin3");
      cur_req = "R10";
      ack_pulse("R9 hold during ack", 1, 17, 0);
      wait_cyc(3);
      out_chk(1, 19, 0, "R2 level mode pin3 presented after ack");
      ack_pulse("R9 hold during ack of level source", 1, 19, 0);
      wait_cyc(3);
      out_chk(1, 19, 0, "R10 level flag survives acknowledge");
      cur_req = "R3";
      pin_set(3, 1); wait_cyc(6);
      out_chk(1, 19, 0, "R3 level flag sticky after release");
      wr(7, 32'h8); wait_cyc(3);
      out_chk(0, 0, 0, "R3 write one clears flag");
      cur_req = "R2";
      pin_set(2, 0); wait_cyc(6);
      out_chk(1, 18, 0, "R2 both-edge mode sees fall");
      wr(7, 32'h4);
      pin_set(2, 1); wait_cyc(6);
      out_chk(1, 18, 0, "R2 both-edge mode sees rise");
      wr(7, 32'h4); wait_cyc(3);
      cur_req = "R4";
      pin_set(4, 0); wait_cyc(6);
      out_chk(0, 0, 0, "R4 disabled pin raises no request");
      rd_chk(7, 32'h10, "R4 flag sets while disabled");
      wr(0, 32'h1F); wait_cyc(3);
      out_chk(1, 20, 0, "R4 enabling pin4 presents vector 20");
      wr(7, 32'h10); wait_cyc(3);
      cur_req = "R6";
      pin_set(0, 0); wait_cyc(6);
      out_chk(1, 16, 0, "R6 baseline pin0 request");
      @(negedge clk) cpu_mask_bit = 1'b1;
      wait_cyc(3);
      out_chk(0, 0, 0, "R6 mask bit blocks all sources");
      @(negedge clk) cpu_mask_bit = 1'b0;
      wait_cyc(3);
      out_chk(1, 16, 0, "R6 unmask restores request");
      wr(7, 32'h1);
      pin_set(0, 1); wait_cyc(6);
      out_chk(0, 0, 0, "R3 all flags cleared");

      // internal sources, leveled mode
      cur_req = "R5";
      wr(1, 32'hFF);
      @(negedge clk) int_flag = 8'h03;
      wait_cyc(3);
      out_chk(1, 32, 0, "R5 internal source 0 vector 32");
      cur_req = "R8";
      wr(3, 1); wait_cyc(3);
      out_chk(0, 0, 0, "R8 level 0 not above mask 0");
      cur_req = "R7";
      wr(6, 32'h003); wait_cyc(3);
      out_chk(1, 32, 3, "R7 fixed order inside module");
      cur_req = "R8";
      @(negedge clk) cpu_mask_lvl = 3'd3;
      wait_cyc(3);
      out_chk(0, 0, 0, "R8 equal level masked");
      @(negedge clk) cpu_mask_lvl = 3'd2;
      wait_cyc(3);
      out_chk(1, 32, 3, "R8 level above mask accepted");
      cur_req = "R7";
      @(negedge clk) int_flag = 8'h13;
      wr(6, 32'h503); wait_cyc(3);
      out_chk(1, 36, 5, "R7 higher level beats lower vector");
      wr(6, 32'h505); wait_cyc(3);
      out_chk(1, 32, 5, "R7 equal levels fall back to vector order");
      cur_req = "R8";
      wr(6, 32'h707);
      @(negedge clk) cpu_mask_lvl = 3'd7;
      wait_cyc(3);
      out_chk(1, 32, 7, "R8 level 7 always accepted");
      cur_req = "R11";
      wr(4, 32'h01); wait_cyc(3);
      out_chk(1, 33, 7, "R11 steered source leaves arbitration");
      check("R11 steered trigger", 32'(dma_trig), 32'h01);
      wr(3, 0);
      @(negedge clk) cpu_mask_bit = 1'b1;
      wait_cyc(3);
      out_chk(0, 0, 0, "R11 CPU masked in fixed mode");
      #1 check("R11 trigger ignores mode and mask", 32'(dma_trig), 32'h01);
      wr(1, 32'hFE); wait_cyc(2);
      #1 check("R11 trigger needs enable", 32'(dma_trig), 32'h00);

      // random mix
      cur_req = "R2/R3/R5/R7/R9/R10/R11";
      @(negedge clk) begin cpu_mask_bit = 1'b0; cpu_mask_lvl = 3'd0; end
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         if ($urandom % 6 == 0) ext_pin[$urandom % 16] = ~ext_pin[$urandom % 16];
         if ($urandom % 8 == 0) int_flag = 8'($urandom);
         irq_ack = ($urandom % 4 == 0);
         if ($urandom % 40 == 0) cpu_mask_lvl = 3'($urandom);
         if ($urandom % 50 == 0) cpu_mask_bit = ~cpu_mask_bit;
         reg_we = 1'b0;
         if ($urandom % 12 == 0) begin
            reg_we = 1'b1;
            reg_addr = 4'($urandom % 8);
            reg_wdata = $urandom;
            if (reg_addr == 0) reg_wdata = reg_wdata | 32'hFFFF;
         end
      end
      @(negedge clk) begin reg_we = 1'b0; irq_ack = 1'b0; end
      wait_cyc(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule